// File: doc/BRIEF.md
# Character-Cell Text Raster Generator

This block turns a buffer of character words into a stream of monochrome pixels for the active area of a text screen. The screen is a grid of character cells, 80 across and 25 down by default. Each cell occupies one full 16-bit word of a shared screen memory, so one character never shares a word with another. Each cell is drawn as a 6-pixel by 10-pixel glyph, which gives an active raster of 480 by 250 pixels. The raster is scanned left to right along each pixel line and top to bottom down the screen.

For every pixel-enable pulse, the block does three things. It issues a read to the screen memory for the cell under the scan position. It uses the low 7 bits of the returned word, together with the glyph line, to look up a 6-bit row pattern in an internal glyph RAM. It then emits the pixel picked out by the horizontal position inside the glyph. The glyph RAM is loaded through a plain write port, so no external image file is needed. The output carries markers for the first pixel of each frame and the first pixel of each raster line. The output runs a fixed two cycles behind the enable that produced it.

Top module: `text_raster_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the scan position is the top-left cell: `scr_addr` equals the screen base address. `pixel_valid`, `pixel_out`, `frame_start` and `line_start` are low. Any pixel still in the pipeline when reset arrives is discarded and never appears.
- R2: In a cycle with `pix_en` high, `scr_rd` is high and `scr_addr` equals SCREEN_BASE + row*COLS + col for the current cell (default base 0x0800). When `pix_en` is low, `scr_rd` is low.
- R3: Only bits [6:0] of the screen word select the glyph. Bits [15:7] have no effect on the pixels produced.
- R4: The glyph RAM holds one row pattern per code and glyph line, at address code*GLYPH_H + line. It is written with `gl_wr_en`, `gl_wr_addr` and `gl_wr_data`. Bit GLYPH_W-1 of a pattern is the leftmost pixel, and a 1 bit gives `pixel_out` high.
- R5: The position advances one pixel per enable, in this order: pixel within glyph (0..GLYPH_W-1), then column, then glyph line (0..GLYPH_H-1), then text row. After the last pixel of the last row it wraps to the top-left cell.
- R6: Each enabled cycle produces exactly one output pixel with `pixel_valid` high, exactly two cycles later. Pixels come out in the order they were enabled.
- R7: `frame_start` is high only with the pixel at glyph pixel 0, column 0, line 0, row 0. `line_start` is high only with pixels at glyph pixel 0 of column 0, on every raster line.
- R8: Whenever `pixel_valid` is low, `pixel_out`, `frame_start` and `line_start` are low.
- R9: A cycle with `pix_en` low leaves the scan position and `scr_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel enable: advance the scan by one pixel |
| scr_rd | output | 1 | Screen memory read strobe |
| scr_addr | output | ADDR_W | Screen memory word address |
| scr_data | input | WORD_W | Screen word, valid one cycle after the read |
| gl_wr_en | input | 1 | Glyph RAM write enable |
| gl_wr_addr | input | GA_W | Glyph RAM write address (code*GLYPH_H + line) |
| gl_wr_data | input | GLYPH_W | Glyph row pattern, MSB is the leftmost pixel |
| pixel_out | output | 1 | Output pixel, 1 = lit |
| pixel_valid | output | 1 | Output pixel is valid |
| frame_start | output | 1 | Output pixel is the first pixel of the frame |
| line_start | output | 1 | Output pixel is the first pixel of a raster line |

## Verification
The bench builds the block with a 4-column by 3-row grid and keeps the default 6x10 glyph cell, 7-bit code and screen base. A whole frame is then only 720 pixels. This lets the bench cover frame wrap-around, a second frame start and every line-start position in a short run, while still using the full glyph RAM depth. The screen words carry non-zero upper bits, some with bit 7 set, so any dependence on bits above the code shows up as wrong pixels. The scan is driven continuously, with a regular gap pattern, with pseudo-random gaps, and with a reset in the middle of a frame.

// File: rtl/text_raster_pkg.sv
package text_raster_pkg;

    // Width needed to hold values 0..n-1, never less than one bit.
    function automatic int cw(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Side-band markers carried alongside each pixel through the pipeline.
    typedef struct packed {
        logic valid;
        logic frame;
        logic line;
    } mark_t;

endpackage

// File: rtl/wrap_count.sv
// Counter that advances on inc and wraps to zero after N-1.
module wrap_count #(
    parameter int N = 2,
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] val
);
    always_ff @(posedge clk) begin
        if (rst)
            val <= '0;
        else if (inc)
            val <= (val == W'(N - 1)) ? '0 : val + 1'b1;
    end
endmodule

// File: rtl/glyph_store.sv
// Single-port-write, single-port-read glyph pattern RAM with registered read.
module glyph_store #(
    parameter int DEPTH = 1280,
    parameter int DW    = 6,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/text_raster_gen.sv
module text_raster_gen import text_raster_pkg::*; #(
    parameter int COLS        = 80,
    parameter int ROWS        = 25,
    parameter int GLYPH_W     = 6,
    parameter int GLYPH_H     = 10,
    parameter int CODE_W      = 7,
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 16,
    parameter int SCREEN_BASE = 'h0800,
    localparam int GA_W       = cw((1 << CODE_W) * GLYPH_H)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_en,
    output logic              scr_rd,
    output logic [ADDR_W-1:0] scr_addr,
    input  logic [WORD_W-1:0] scr_data,
    input  logic              gl_wr_en,
    input  logic [GA_W-1:0]   gl_wr_addr,
    input  logic [GLYPH_W-1:0] gl_wr_data,
    output logic              pixel_out,
    output logic              pixel_valid,
    output logic              frame_start,
    output logic              line_start
);
    localparam int XW       = cw(GLYPH_W);
    localparam int CLW      = cw(COLS);
    localparam int LW       = cw(GLYPH_H);
    localparam int RW       = cw(ROWS);
    localparam int GL_DEPTH = (1 << CODE_W) * GLYPH_H;
    localparam logic [WORD_W-1:0] CODE_MASK = WORD_W'((1 << CODE_W) - 1);

    // ---------------- scan position (stage 0) ----------------
    logic [XW-1:0]  x;
    logic [CLW-1:0] col;
    logic [LW-1:0]  line;
    logic [RW-1:0]  row;
    logic           inc_col, inc_line, inc_row;

    assign inc_col  = pix_en  && (x    == XW'(GLYPH_W - 1));
    assign inc_line = inc_col && (col  == CLW'(COLS - 1));
    assign inc_row  = inc_line && (line == LW'(GLYPH_H - 1));

    wrap_count #(.N(GLYPH_W), .W(XW))  u_x    (.clk(clk), .rst(rst), .inc(pix_en),   .val(x));
    wrap_count #(.N(COLS),    .W(CLW)) u_col  (.clk(clk), .rst(rst), .inc(inc_col),  .val(col));
    wrap_count #(.N(GLYPH_H), .W(LW))  u_line (.clk(clk), .rst(rst), .inc(inc_line), .val(line));
    wrap_count #(.N(ROWS),    .W(RW))  u_row  (.clk(clk), .rst(rst), .inc(inc_row),  .val(row));

    assign scr_rd   = pix_en;
    assign scr_addr = ADDR_W'(SCREEN_BASE) + ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(col);

    logic  at_left;
    mark_t m0;
    assign at_left  = (x == '0) && (col == '0);
    assign m0.valid = pix_en;
    assign m0.line  = pix_en && at_left;
    assign m0.frame = pix_en && at_left && (line == '0) && (row == '0);

    // ---------------- stage 1: screen word arrives ----------------
    mark_t         m1;
    logic [XW-1:0] x1;
    logic [LW-1:0] l1;
    logic [GA_W-1:0] gaddr;

    // Only the code bits of the word take part in the glyph address.
    assign gaddr = GA_W'((scr_data & CODE_MASK) * WORD_W'(GLYPH_H) + WORD_W'(l1));

    // ---------------- stage 2: glyph row arrives ----------------
    mark_t            m2;
    logic [XW-1:0]    x2;
    logic [GLYPH_W-1:0] glyph_row;

    glyph_store #(.DEPTH(GL_DEPTH), .DW(GLYPH_W), .AW(GA_W)) u_glyph (
        .clk   (clk),
        .we    (gl_wr_en),
        .waddr (gl_wr_addr),
        .wdata (gl_wr_data),
        .raddr (gaddr),
        .rdata (glyph_row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            m1 <= '0;
            x1 <= '0;
            l1 <= '0;
            m2 <= '0;
            x2 <= '0;
        end else begin
            m1 <= m0;
            x1 <= x;
            l1 <= line;
            m2 <= m1;
            x2 <= x1;
        end
    end

    // Leftmost pixel is the pattern's most significant bit.
    assign pixel_out   = m2.valid && glyph_row[XW'(GLYPH_W - 1) - x2];
    assign pixel_valid = m2.valid;
    assign frame_start = m2.frame;
    assign line_start  = m2.line;

endmodule

// File: rtl/text_raster_chk.sv
module text_raster_chk #(
    parameter int ADDR_W = 16,
    parameter int BASE   = 'h0800,
    parameter int CELLS  = 2000
) (
    input logic              clk,
    input logic              rst,
    input logic              pix_en,
    input logic              scr_rd,
    input logic [ADDR_W-1:0] scr_addr,
    input logic              pixel_valid,
    input logic              pixel_out,
    input logic              frame_start,
    input logic              line_start
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!pixel_valid && scr_addr == ADDR_W'(BASE)));

    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        scr_rd |-> (scr_addr >= ADDR_W'(BASE) && scr_addr <= ADDR_W'(BASE + CELLS - 1)));

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        pixel_valid |-> $past(pix_en, 2));

    // R7
    frame_line_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> line_start);

    // R8
    blank_chk: assert property (@(posedge clk) disable iff (rst)
        !pixel_valid |-> (!pixel_out && !frame_start && !line_start));

    // R9
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> $stable(scr_addr));
endmodule

bind text_raster_gen text_raster_chk #(
    .ADDR_W (ADDR_W),
    .BASE   (SCREEN_BASE),
    .CELLS  (COLS * ROWS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pix_en      (pix_en),
    .scr_rd      (scr_rd),
    .scr_addr    (scr_addr),
    .pixel_valid (pixel_valid),
    .pixel_out   (pixel_out),
    .frame_start (frame_start),
    .line_start  (line_start)
);

// File: tb/text_raster_gen_test.sv
`timescale 1ns/1ps
module text_raster_gen_test;
    localparam int COLS = 4;
    localparam int ROWS = 3;
    localparam int GW   = 6;
    localparam int GH   = 10;
    localparam int BASE = 'h0800;
    localparam int CELLS = COLS * ROWS;

    logic        clk = 0;
    logic        rst = 1;
    logic        pix_en = 0;
    logic        scr_rd;
    logic [15:0] scr_addr;
    logic [15:0] scr_q = '0;
    logic        gl_wr_en = 0;
    logic [10:0] gl_wr_addr = '0;
    logic [5:0]  gl_wr_data = '0;
    logic        pixel_out, pixel_valid, frame_start, line_start;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mx = 0, mc = 0, ml = 0, mr = 0;
    logic [15:0] scr_mem [CELLS];
    int          exp_t [$];
    logic [2:0]  exp_v [$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    text_raster_gen #(.COLS(COLS), .ROWS(ROWS), .GLYPH_W(GW), .GLYPH_H(GH)) uut (
        .clk(clk), .rst(rst), .pix_en(pix_en), .scr_rd(scr_rd), .scr_addr(scr_addr),
        .scr_data(scr_q), .gl_wr_en(gl_wr_en), .gl_wr_addr(gl_wr_addr),
        .gl_wr_data(gl_wr_data), .pixel_out(pixel_out), .pixel_valid(pixel_valid),
        .frame_start(frame_start), .line_start(line_start)
    );

    // Screen memory model: synchronous read, one cycle.
    always @(posedge clk) begin
        if (scr_rd) begin
            if (int'(scr_addr) >= BASE && int'(scr_addr) < BASE + CELLS)
                scr_q <= scr_mem[int'(scr_addr) - BASE];
            else
                scr_q <= 16'hDEAD;
        end
    end

    function automatic logic [5:0] gpat(input int code, input int ln);
        return 6'((code * 7 + ln * 13 + 5) ^ (code >> 2));
    endfunction

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic int model_addr();
        return BASE + mr * COLS + mc;
    endfunction

    task automatic model_step();
        mx++;
        if (mx == GW) begin
            mx = 0; mc++;
            if (mc == COLS) begin
                mc = 0; ml++;
                if (ml == GH) begin
                    ml = 0; mr++;
                    if (mr == ROWS) mr = 0;
                end
            end
        end
    endtask

    // Driver: mode 0 continuous, 1 regular gaps, 2 pseudo-random gaps.
    task automatic drive(input int n, input int mode);
        logic [7:0] lfsr = 8'hA5;
        for (int k = 0; k < n; k++) begin
            logic en;
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            en = (mode == 0) ? 1'b1 : (mode == 1) ? (k % 3 != 1) : lfsr[0];
            pix_en = en;
            // R2 R9: address follows the model position, stalls on gaps
            chk(scr_addr == 16'(model_addr()), en ? "R2 R5 address" : "R9 stalled address",
                int'(scr_addr), model_addr());
            if (en) begin
                logic [15:0] w;
                logic [5:0]  p;
                w = scr_mem[mr * COLS + mc];
                p = gpat(int'(w[6:0]), ml);
                exp_t.push_back(cyc);
                exp_v.push_back({p[GW - 1 - mx], (mx == 0 && mc == 0 && ml == 0 && mr == 0),
                                 (mx == 0 && mc == 0)});
                model_step();
            end
        end
        @(negedge clk);
        pix_en = 0;
    endtask

    // Monitor: pops expected pixels as the design produces them.
    always @(negedge clk) begin
        if (pixel_valid) begin
            if (exp_t.size() == 0) begin
                chk(1'b0, "R1 R6 unexpected pixel", 1, 0);
            end else begin
                int         t;
                logic [2:0] v;
                t = exp_t.pop_front();
                v = exp_v.pop_front();
                chk(cyc == t + 2, "R6 latency", cyc - t, 2);
                chk(pixel_out == v[2], "R3 R4 pixel", int'(pixel_out), int'(v[2]));
                chk({frame_start, line_start} == v[1:0], "R7 markers",
                    int'({frame_start, line_start}), int'(v[1:0]));
            end
        end else begin
            if (pixel_out || frame_start || line_start)
                chk(1'b0, "R8 blank when idle", int'({pixel_out, frame_start, line_start}), 0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog: cycle %0d expected below %0d", cyc, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < CELLS; i++)
            scr_mem[i] = 16'((((i * 97 + 11) & 16'h1FF) << 7) | ((i * 29 + 3) & 16'h7F));
        repeat (3) @(posedge clk);
        // R4: load every glyph row through the write port
        for (int c = 0; c < 128; c++) begin
            for (int l = 0; l < GH; l++) begin
                @(negedge clk);
                gl_wr_en   = 1;
                gl_wr_addr = 11'(c * GH + l);
                gl_wr_data = gpat(c, l);
            end
        end
        @(negedge clk);
        gl_wr_en = 0;
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(scr_addr == 16'(BASE), "R1 reset address", int'(scr_addr), BASE);
        chk(!pixel_valid && !pixel_out, "R1 reset output", int'({pixel_valid, pixel_out}), 0);
        chk(!frame_start && !line_start, "R1 reset markers", int'({frame_start, line_start}), 0);

        drive(GW * COLS * GH * ROWS + 40, 0);   // R5 wrap into second frame
        drive(600, 1);                          // R9 regular gaps
        drive(900, 2);                          // R9 random gaps
        repeat (4) @(negedge clk);

        // R1: reset mid-frame with a pixel in flight
        pix_en = 1;
        @(negedge clk);
        pix_en = 0;
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        mx = 0; mc = 0; ml = 0; mr = 0;
        @(negedge clk);
        chk(scr_addr == 16'(BASE), "R1 mid-frame reset address", int'(scr_addr), BASE);
        drive(200, 0);
        repeat (4) @(negedge clk);
        chk(exp_t.size() == 0, "R6 all pixels delivered", exp_t.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule